// File: doc/BRIEF.md
# Configurable Interrupt Trigger Detector

This block turns 51 synchronous interrupt request lines into a registered vector of pending bits. Each source has its own trigger rule. A level-sensitive source is either active-high or active-low, and its pending bit follows the line on every clock. An edge-sensitive source reacts to a rising edge, a falling edge, or both. Its pending bit latches and stays set until software clears it explicitly.

The neighbouring configuration logic supplies three per-source vectors, one bit per source:

- the level/edge selector (`trig_level_i`),
- the polarity selector (`trig_polarity_i`),
- the both-edges override (`trig_anyedge_i`).

That logic also supplies a strobe vector for clearing edge events (`edge_clear_i`). The package exports the reset values that the configuration registers should adopt.

The detector keeps a copy of every line's level from the previous clock. Edges are found against that copy. The copy is also visible at the output. All vectors are 64 bits wide. Only bits 0 to 50 are in use.

Top module: `irq_trig_detect`

## Requirements
- R1: While `rst_n` is low, `pend_o` and `prev_o` are all zeros.
- R2: A source with `trig_level_i`=1 is level-sensitive. One clock after a sample, its `pend_o` bit equals the sampled line when `trig_polarity_i`=1, and equals the inverted line when `trig_polarity_i`=0. It drops as soon as the qualified level drops.
- R3: A source with `trig_level_i`=0, `trig_anyedge_i`=0 and `trig_polarity_i`=1 sets its `pend_o` bit one clock after the line goes 0→1. The bit stays set after the line returns to 0.
- R4: A source with `trig_level_i`=0, `trig_anyedge_i`=0 and `trig_polarity_i`=0 sets its `pend_o` bit one clock after the line goes 1→0. A 0→1 change does not set it.
- R5: An edge source with `trig_anyedge_i`=1 sets its `pend_o` bit after any change of its line, whatever `trig_polarity_i` says.
- R6: `prev_o` equals the line vector sampled at the previous clock, for every source in every mode.
- R7: An `edge_clear_i` bit clears the `pend_o` bit of an edge source one clock later. On a level source the clear bit has no effect.
- R8: If an edge is detected and the clear bit is set for the same source in the same cycle, the `pend_o` bit is set afterwards.
- R9: Bits 63 to 51 of `pend_o` and `prev_o` are always 0, whatever is driven on the upper bits of the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| line_i | input | 64 | Synchronous interrupt line levels, bit n is source n |
| trig_level_i | input | 64 | 1 = level-sensitive, 0 = edge-sensitive |
| trig_polarity_i | input | 64 | Level: 1 active-high, 0 active-low. Edge: 1 rising, 0 falling |
| trig_anyedge_i | input | 64 | For edge sources, 1 = both edges trigger |
| edge_clear_i | input | 64 | Per-source strobe clearing a latched edge event |
| pend_o | output | 64 | Raw pending vector |
| prev_o | output | 64 | Line levels sampled at the previous clock |

## Verification
The hardest case to reach from the ports is a new edge that lands in the same clock as the clear for that source. Both the edge and the earlier latched state have to be known at that moment. The bench first latches an event, then moves the line back to its idle level, and then raises the line again in the very cycle the clear strobe is driven. It does the same with sources mixed between level and edge mode, so that a single all-ones clear vector is shown to leave the level sources alone.

// File: rtl/irq_trig_pkg.sv
`timescale 1ns/1ps
package irq_trig_pkg;
  localparam int unsigned VEC_W   = 64;
  localparam int unsigned NUM_SRC = 51;

  // Reset defaults for the neighbouring configuration registers.
  localparam logic [VEC_W-1:0] LEVEL_RST    = 64'h0000_1F07_FFF8_FFFF;
  localparam logic [VEC_W-1:0] ANYEDGE_RST  = 64'h0000_00F8_0007_0000;
  localparam logic [VEC_W-1:0] POLARITY_RST = 64'h0000_5F07_FFF8_FFFF;

  // Encoding is {edge_sel, polarity}.
  typedef enum logic [1:0] {
    TRIG_LVL_LOW   = 2'b00,
    TRIG_LVL_HIGH  = 2'b01,
    TRIG_EDGE_FALL = 2'b10,
    TRIG_EDGE_RISE = 2'b11
  } trig_mode_e;
endpackage

// File: rtl/irq_prev_store.sv
`timescale 1ns/1ps
module irq_prev_store #(
  parameter int unsigned W = 51
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line_i,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] prev_d;
  logic [W-1:0] prev_q;
  logic         prev_en;

  always_comb begin
    prev_d  = line_i;
    prev_en = (prev_d != prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else if (prev_en) begin
      prev_q <= prev_d;
    end
  end

  assign prev_o = prev_q;

  // R6: stored copy is the previous sample
  p_prev_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> prev_q == $past(line_i));
endmodule

// File: rtl/irq_trig_cell.sv
`timescale 1ns/1ps
module irq_trig_cell
  import irq_trig_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic prev_i,
  input  logic level_sel_i,
  input  logic polarity_i,
  input  logic anyedge_i,
  input  logic clear_i,
  output logic pend_o
);
  trig_mode_e mode;
  logic       hit;
  logic       pend_d;
  logic       pend_q;
  logic       pend_en;

  always_comb begin
    mode   = trig_mode_e'({~level_sel_i, polarity_i});
    hit    = 1'b0;
    pend_d = pend_q;
    case (mode)
      TRIG_LVL_HIGH: pend_d = line_i;
      TRIG_LVL_LOW:  pend_d = ~line_i;
      TRIG_EDGE_RISE, TRIG_EDGE_FALL: begin
        if (anyedge_i) begin
          hit = line_i ^ prev_i;
        end else if (mode == TRIG_EDGE_RISE) begin
          hit = line_i & ~prev_i;
        end else begin
          hit = prev_i & ~line_i;
        end
        // A fresh edge outranks a clear in the same cycle.
        pend_d = hit | (pend_q & ~clear_i);
      end
      default: pend_d = pend_q;
    endcase
    pend_en = (pend_d != pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R2: level sources follow the qualified line
  p_level_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    level_sel_i |=> pend_q == $past(line_i == polarity_i));

  // R3: a latched edge is not dropped by the line going idle
  p_edge_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_sel_i && pend_q && !clear_i) |=> pend_q);

  // R5: any change sets the bit when both edges are armed
  p_anyedge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_sel_i && anyedge_i && (line_i != prev_i)) |=> pend_q);

  // R7: a clear with a quiet line empties an edge source
  p_clear_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_sel_i && clear_i && (line_i == prev_i)) |=> !pend_q);
endmodule

// File: rtl/irq_trig_detect.sv
`timescale 1ns/1ps
module irq_trig_detect
  import irq_trig_pkg::*;
#(
  parameter int unsigned NSRC = NUM_SRC,
  parameter int unsigned VW   = VEC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] line_i,
  input  logic [VW-1:0] trig_level_i,
  input  logic [VW-1:0] trig_polarity_i,
  input  logic [VW-1:0] trig_anyedge_i,
  input  logic [VW-1:0] edge_clear_i,
  output logic [VW-1:0] pend_o,
  output logic [VW-1:0] prev_o
);
  localparam int unsigned PAD_W = VW - NSRC;

  logic [NSRC-1:0] prev_vec;
  logic [NSRC-1:0] pend_vec;

  irq_prev_store #(.W(NSRC)) u_prev (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (line_i[NSRC-1:0]),
    .prev_o (prev_vec)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    irq_trig_cell u_cell (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_i      (line_i[g]),
      .prev_i      (prev_vec[g]),
      .level_sel_i (trig_level_i[g]),
      .polarity_i  (trig_polarity_i[g]),
      .anyedge_i   (trig_anyedge_i[g]),
      .clear_i     (edge_clear_i[g]),
      .pend_o      (pend_vec[g])
    );
  end

  if (PAD_W > 0) begin : g_pad
    logic unused_hi;
    assign unused_hi = ^{line_i[VW-1:NSRC], trig_level_i[VW-1:NSRC],
                         trig_polarity_i[VW-1:NSRC], trig_anyedge_i[VW-1:NSRC],
                         edge_clear_i[VW-1:NSRC]};
    assign pend_o = {{PAD_W{1'b0}}, pend_vec};
    assign prev_o = {{PAD_W{1'b0}}, prev_vec};

    // R9: unused upper positions stay zero
    p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o[VW-1:NSRC] == '0) && (prev_o[VW-1:NSRC] == '0));
  end else begin : g_nopad
    assign pend_o = pend_vec;
    assign prev_o = prev_vec;
  end

  // R1: reset clears both vectors
  always_comb begin
    if (!rst_n) begin
      a_reset_clear_r1: assert (pend_o == '0 && prev_o == '0 || $isunknown(rst_n));
    end
  end
endmodule

// File: tb/irq_trig_detect_bench.sv
`timescale 1ns/1ps
module irq_trig_detect_bench;
  import irq_trig_pkg::*;

  localparam int unsigned N = NUM_SRC;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] line, lvl, pol, anye, eclr;
  logic [63:0] pend, prev;
  logic [63:0] m_pend, m_prev;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  irq_trig_detect u_irq_trig_detect (
    .clk (clk), .rst_n (rst_n), .line_i (line), .trig_level_i (lvl),
    .trig_polarity_i (pol), .trig_anyedge_i (anye), .edge_clear_i (eclr),
    .pend_o (pend), .prev_o (prev)
  );

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Model update from the requirements, using the values seen at the edge.
  task automatic model_edge();
    logic [63:0] np;
    np = '0;
    for (int i = 0; i < N; i++) begin
      logic h;
      if (lvl[i]) begin
        np[i] = pol[i] ? line[i] : ~line[i];
      end else begin
        if (anye[i]) h = line[i] ^ m_prev[i];
        else if (pol[i]) h = line[i] & ~m_prev[i];
        else h = m_prev[i] & ~line[i];
        np[i] = h | (m_pend[i] & ~eclr[i]);
      end
    end
    m_pend = np;
    m_prev = {{(64-N){1'b0}}, line[N-1:0]};
  endtask

  task automatic step(input logic [63:0] ln, input logic [63:0] cl, input string tag);
    line = ln;
    eclr = cl;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, "pend", pend, m_pend);
    check(tag, "prev", prev, m_prev);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    line = '1; lvl = LEVEL_RST; pol = POLARITY_RST; anye = ANYEDGE_RST; eclr = '0;
    m_pend = '0; m_prev = '0;
    repeat (3) @(negedge clk);
    check("R1", "pend in reset", pend, 64'h0);
    check("R1", "prev in reset", prev, 64'h0);
    line = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_prev = '0;
    check("R1", "pend after release", pend, 64'h0);
  endtask

  task automatic t_level();
    lvl = '1; pol = 64'h5555_5555_5555_5555; anye = '0;
    step(64'h0, 64'h0, "R2");
    step(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R2");
    step(64'h0000_A5A5_0F0F_3C3C, 64'h0, "R2");
    step(64'h0000_A5A5_0F0F_3C3C, '1, "R7");
    step(64'h0, 64'h0, "R2");
  endtask

  task automatic t_rise();
    lvl = '0; pol = '1; anye = '0;
    step(64'h0, '1, "R3");
    step(64'h0000_0000_00FF_00F0, 64'h0, "R3");
    step(64'h0, 64'h0, "R3");
    step(64'h0, 64'h0, "R3");
    step(64'h0, '1, "R7");
  endtask

  task automatic t_fall();
    lvl = '0; pol = '0; anye = '0;
    step(64'h0007_FFFF_FFFF_FFFF, 64'h0, "R4");
    step(64'h0007_FFFF_0000_FFFF, 64'h0, "R4");
    step(64'h0007_FFFF_FFFF_FFFF, 64'h0, "R4");
    step(64'h0007_FFFF_FFFF_FFFF, '1, "R7");
  endtask

  task automatic t_anyedge();
    lvl = '0; anye = '1; pol = 64'h0000_F0F0_F0F0_F0F0;
    step(64'h0, '1, "R5");
    step(64'h0000_0000_0000_0F0F, 64'h0, "R5");
    step(64'h0000_0000_0000_0F0F, '1, "R5");
    step(64'h0, 64'h0, "R5");
    step(64'h0, '1, "R5");
  endtask

  task automatic t_prev();
    lvl = LEVEL_RST; pol = POLARITY_RST; anye = ANYEDGE_RST;
    step(64'h0003_1234_5678_9ABC, 64'h0, "R6");
    step(64'h0004_FEDC_BA98_7654, 64'h0, "R6");
    step(64'h0001_0F0F_F0F0_AAAA, 64'h0, "R6");
    step(64'h0, '1, "R6");
  endtask

  task automatic t_clear_mix();
    lvl = 64'h0000_FFFF_0000_FFFF; pol = '1; anye = '0;
    step(64'h0, '1, "R7");
    step(64'h0007_FFFF_FFFF_FFFF, 64'h0, "R7");
    step(64'h0007_FFFF_FFFF_FFFF, '1, "R7");
    check("R7", "level bits after clear", pend & lvl, lvl & 64'h0007_FFFF_FFFF_FFFF);
    check("R7", "edge bits after clear", pend & ~lvl, 64'h0);
  endtask

  task automatic t_collide();
    lvl = '0; pol = '1; anye = '0;
    step(64'h0, '1, "R8");
    step(64'h1, 64'h0, "R8");
    step(64'h0, 64'h0, "R8");
    step(64'h1, 64'h1, "R8");
    check("R8", "edge beats clear", pend[0], 1'b1);
    step(64'h1, 64'h1, "R8");
    check("R8", "later clear empties", pend[0], 1'b0);
  endtask

  task automatic t_upper();
    lvl = '1; pol = '1; anye = '1;
    step('1, '1, "R9");
    check("R9", "pend upper", pend & 64'hFFF8_0000_0000_0000, 64'h0);
    check("R9", "prev upper", prev & 64'hFFF8_0000_0000_0000, 64'h0);
    lvl = '0;
    step('0, '0, "R9");
    step('1, '0, "R9");
    check("R9", "edge pend upper", pend & 64'hFFF8_0000_0000_0000, 64'h0);
  endtask

  initial begin
    t_reset();
    t_level();
    t_rise();
    t_fall();
    t_anyedge();
    t_prev();
    t_clear_mix();
    t_collide();
    t_upper();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule